// File: doc/BRIEF.md
# Shared-Adder Centre-of-Gravity Defuzzifier

This block turns up to four fired-rule weights and their four precomputed weight-times-location products into one crisp 8-bit output. It uses neither a multiplier nor a divider. A single adder tree is used twice per inference. In the first pass it totals the weights. In the second pass it totals the products, which were fetched into a holding register while the first pass was settling. The two clamped totals are joined into one table address. The quotient table at that address holds the rounded, scaled centre of gravity. Its contents depend only on the two sum widths, so a change to the rule base never requires new table contents.

A one-hot sequencer orders every register load in the path. It also drives three single-cycle load strobes to the upstream input, minimum and rule-selection stages, so the whole inference chain runs from one start pulse. Each step lasts a set number of clocks, fixed by parameters, so that slow paths have time to settle. With the default dwell values, one inference takes 24 clocks.

Top module: `fz_cog_defuzz`

## Requirements
- R1: For weights w0..w3 (4 bits each, `wgt_i[4k+3:4k]`) and products p0..p3 (8 bits each, `prod_i[8k+7:8k]`), let W be the sum of the weights and P the sum of the products. The crisp output is 16·P/W rounded to the nearest integer, computed as floor((32·P + W) / (2·W)).
- R2: When W is zero, the crisp output is 0.
- R3: W is clamped to 31 before lookup and P is clamped to 511, so a weight total above 31 yields the result for W = 31.
- R4: A quotient above 255 is returned as 255.
- R5: Counting the rising edge that accepts start as edge 0, `lat_in_o` is high for exactly the cycle after edge 0, `lat_min_o` for exactly the cycle after edge 3, and `lat_red_o` for exactly the cycle after edge 6.
- R6: `done_o` is high for exactly one cycle, the cycle after edge 23. `crisp_o` takes its new value at edge 23 and keeps it until the next done.
- R7: Exactly one controller state bit is set at any time.
- R8: Weights and products are sampled once, at edge 11. Input changes before that edge are used, and input changes after it have no effect on the result.
- R9: A start strobe that arrives while an inference is in progress is ignored. It produces no extra load strobe and no extra done, and the running result is unchanged.
- R10: After reset, `crisp_o`, `done_o` and all three load strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins an inference when the block is idle |
| wgt_i | input | 16 | Four rule weights, weight k in bits 4k+3..4k |
| prod_i | input | 32 | Four weight-location products, product k in bits 8k+7..8k |
| crisp_o | output | 8 | Crisp centre-of-gravity result |
| done_o | output | 1 | One-cycle pulse when crisp_o updates |
| lat_in_o | output | 1 | Load strobe for the upstream input register |
| lat_min_o | output | 1 | Load strobe for the upstream minimum stage |
| lat_red_o | output | 1 | Load strobe for the upstream rule-selection stage |

## Verification
Two events can collide in one cycle: a fresh start strobe and the controller's own progress through a running inference. The shared operand register must also not pick up new input values while it is being reloaded for the product pass. The bench raises start in the middle of a run, once during the rule-selection wait and once during the product pass. It also changes the inputs before and after the sampling edge. A run is judged correct when every strobe and the done pulse appear exactly once at their fixed cycles, and the result matches the inputs that were present at the sampling edge. Directed cases for a zero weight total, a clamped weight total and a clamped quotient complete the coverage.

// File: rtl/fz_cog_pkg.sv
package fz_cog_pkg;

   // one-hot state bit positions; the order is the processing sequence
   localparam int unsigned S_IDLE = 0;
   localparam int unsigned S_LIN  = 1;
   localparam int unsigned S_LMIN = 2;
   localparam int unsigned S_LRED = 3;
   localparam int unsigned S_LDW  = 4;
   localparam int unsigned S_CAPW = 5;
   localparam int unsigned S_LDP  = 6;
   localparam int unsigned S_CAPP = 7;
   localparam int unsigned S_RDQ  = 8;
   localparam int unsigned S_OUT  = 9;
   localparam int unsigned NST    = 10;

   // value stored at one quotient table address
   function automatic int unsigned cog_quot(input int unsigned psum,
                                            input int unsigned wsum,
                                            input int unsigned scale,
                                            input int unsigned maxv);
      int unsigned q;
      if (wsum == 0) return 0;
      q = (2 * scale * psum + wsum) / (2 * wsum);
      if (q > maxv) q = maxv;
      return q;
   endfunction

endpackage

// File: rtl/fz_cog_ctrl.sv
module fz_cog_ctrl
   import fz_cog_pkg::*;
#(
   parameter int unsigned D_IN  = 3,
   parameter int unsigned D_MIN = 3,
   parameter int unsigned D_RED = 4,
   parameter int unsigned D_ADD = 4,
   parameter int unsigned D_TBL = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   output logic [NST-1:0] state_o,
   output logic           en_in_o,
   output logic           en_min_o,
   output logic           en_red_o,
   output logic           ld_w_o,
   output logic           cap_w_o,
   output logic           ld_p_o,
   output logic           cap_p_o,
   output logic           rd_q_o,
   output logic           out_en_o
);

   localparam int unsigned DMAX_A = (D_IN > D_MIN) ? D_IN : D_MIN;
   localparam int unsigned DMAX_B = (D_RED > D_ADD) ? D_RED : D_ADD;
   localparam int unsigned DMAX_C = (DMAX_A > DMAX_B) ? DMAX_A : DMAX_B;
   localparam int unsigned DMAX   = (DMAX_C > D_TBL) ? DMAX_C : D_TBL;
   localparam int unsigned CNT_W  = (DMAX < 2) ? 1 : $clog2(DMAX);

   function automatic int unsigned dwell_of(input int unsigned idx);
      case (idx)
         S_LIN:  return D_IN;
         S_LMIN: return D_MIN;
         S_LRED: return D_RED;
         S_LDW:  return D_ADD;
         S_LDP:  return D_ADD;
         S_RDQ:  return D_TBL;
         default: return 1;
      endcase
   endfunction

   logic [NST-1:0]   st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;
   logic             at_last;
   logic             first;

   always_comb begin
      last_cnt = '0;
      for (int i = 0; i < int'(NST); i++) begin
         if (st_q[i]) last_cnt = CNT_W'(dwell_of(i) - 1);
      end
   end

   assign at_last = (cnt_q == last_cnt);
   assign first   = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= NST'(1) << S_IDLE;
         cnt_q <= '0;
      end else if (st_q[S_IDLE]) begin
         cnt_q <= '0;
         if (start_i) st_q <= NST'(1) << S_LIN;
      end else if (at_last) begin
         cnt_q <= '0;
         st_q  <= {st_q[NST-2:0], st_q[NST-1]};
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign state_o  = st_q;
   assign en_in_o  = st_q[S_LIN]  & first;
   assign en_min_o = st_q[S_LMIN] & first;
   assign en_red_o = st_q[S_LRED] & first;
   assign ld_w_o   = st_q[S_LDW]  & first;
   assign cap_w_o  = st_q[S_CAPW];
   assign ld_p_o   = st_q[S_LDP]  & first;
   assign cap_p_o  = st_q[S_CAPP];
   assign rd_q_o   = st_q[S_RDQ]  & first;
   assign out_en_o = st_q[S_OUT];

endmodule

// File: rtl/fz_cog_addtree.sv
module fz_cog_addtree #(
   parameter int unsigned N     = 4,
   parameter int unsigned IN_W  = 8,
   parameter int unsigned OUT_W = IN_W + $clog2(N)
) (
   input  logic [N*IN_W-1:0] opr_i,
   output logic [OUT_W-1:0]  sum_o
);

   localparam int unsigned LV = $clog2(N);
   localparam int unsigned NP = 1 << LV;

   logic [OUT_W-1:0] node [1:2*NP-1];

   genvar g;
   generate
      for (g = 0; g < int'(NP); g++) begin : g_leaf
         if (g < int'(N)) begin : g_used
            assign node[NP+g] = OUT_W'(opr_i[g*IN_W +: IN_W]);
         end else begin : g_pad
            assign node[NP+g] = '0;
         end
      end
      for (g = 1; g < int'(NP); g++) begin : g_inner
         assign node[g] = node[2*g] + node[2*g+1];
      end
   endgenerate

   assign sum_o = node[1];

endmodule

// File: rtl/fz_cog_qtable.sv
module fz_cog_qtable
   import fz_cog_pkg::*;
#(
   parameter int unsigned SUMW_W    = 5,
   parameter int unsigned SUMP_W    = 9,
   parameter int unsigned OUT_W     = 8,
   parameter int unsigned SCALE     = 16,
   parameter bit          TABLE_ROM = 1'b0
) (
   input  logic [SUMP_W+SUMW_W-1:0] addr_i,
   output logic [OUT_W-1:0]         data_o
);

   localparam int unsigned ADDR_W = SUMP_W + SUMW_W;
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned OMAX   = (1 << OUT_W) - 1;

   generate
      if (TABLE_ROM) begin : g_rom
         logic [OUT_W-1:0] rom [DEPTH];
         initial begin
            for (int a = 0; a < int'(DEPTH); a++) begin
               rom[a] = OUT_W'(cog_quot(a >> SUMW_W,
                                        a & ((1 << SUMW_W) - 1),
                                        SCALE, OMAX));
            end
         end
         assign data_o = rom[addr_i];
      end else begin : g_calc
         assign data_o = OUT_W'(cog_quot(32'(addr_i[ADDR_W-1:SUMW_W]),
                                         32'(addr_i[SUMW_W-1:0]),
                                         SCALE, OMAX));
      end
   endgenerate

endmodule

// File: rtl/fz_cog_defuzz.sv
module fz_cog_defuzz
   import fz_cog_pkg::*;
#(
   parameter int unsigned NRULE     = 4,
   parameter int unsigned WGT_W     = 4,
   parameter int unsigned PROD_W    = 8,
   parameter int unsigned SUMW_W    = 5,
   parameter int unsigned SUMP_W    = 9,
   parameter int unsigned OUT_W     = 8,
   parameter int unsigned SCALE     = 16,
   parameter int unsigned D_IN      = 3,
   parameter int unsigned D_MIN     = 3,
   parameter int unsigned D_RED     = 4,
   parameter int unsigned D_ADD     = 4,
   parameter int unsigned D_TBL     = 2,
   parameter bit          TABLE_ROM = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [NRULE*WGT_W-1:0]  wgt_i,
   input  logic [NRULE*PROD_W-1:0] prod_i,
   output logic [OUT_W-1:0]        crisp_o,
   output logic                    done_o,
   output logic                    lat_in_o,
   output logic                    lat_min_o,
   output logic                    lat_red_o
);

   localparam int unsigned OPW    = (WGT_W > PROD_W) ? WGT_W : PROD_W;
   localparam int unsigned TREE_W = OPW + $clog2(NRULE);
   localparam int unsigned ADDR_W = SUMP_W + SUMW_W;
   localparam logic [SUMW_W-1:0] SUMW_MAX = '1;
   localparam logic [SUMP_W-1:0] SUMP_MAX = '1;

   initial begin
      assert (NRULE >= 2) else $fatal(1, "NRULE must be at least 2");
      assert (SUMW_W <= TREE_W && SUMP_W <= TREE_W)
         else $fatal(1, "sum registers wider than adder tree");
      assert (D_IN >= 1 && D_MIN >= 1 && D_RED >= 1 && D_ADD >= 1 && D_TBL >= 1)
         else $fatal(1, "dwell counts must be at least 1");
   end

   logic [NST-1:0] ctl_state;
   logic ld_w, cap_w, ld_p, cap_p, rd_q, out_en;

   fz_cog_ctrl #(
      .D_IN (D_IN), .D_MIN(D_MIN), .D_RED(D_RED),
      .D_ADD(D_ADD), .D_TBL(D_TBL)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .state_o  (ctl_state),
      .en_in_o  (lat_in_o),
      .en_min_o (lat_min_o),
      .en_red_o (lat_red_o),
      .ld_w_o   (ld_w),
      .cap_w_o  (cap_w),
      .ld_p_o   (ld_p),
      .cap_p_o  (cap_p),
      .rd_q_o   (rd_q),
      .out_en_o (out_en)
   );

   // shared operand register and product holding register
   logic [NRULE*OPW-1:0]    opr_q;
   logic [NRULE*PROD_W-1:0] phold_q;
   logic [NRULE*OPW-1:0]    wgt_ext;
   logic [NRULE*OPW-1:0]    prod_ext;

   genvar g;
   generate
      for (g = 0; g < int'(NRULE); g++) begin : g_ext
         assign wgt_ext[g*OPW +: OPW]  = OPW'(wgt_i[g*WGT_W +: WGT_W]);
         assign prod_ext[g*OPW +: OPW] = OPW'(phold_q[g*PROD_W +: PROD_W]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opr_q   <= '0;
         phold_q <= '0;
      end else if (ld_w) begin
         opr_q   <= wgt_ext;
         phold_q <= prod_i;
      end else if (ld_p) begin
         opr_q   <= prod_ext;
      end
   end

   logic [TREE_W-1:0] tree_sum;

   fz_cog_addtree #(
      .N(NRULE), .IN_W(OPW), .OUT_W(TREE_W)
   ) u_tree (
      .opr_i (opr_q),
      .sum_o (tree_sum)
   );

   // clamped sum capture
   logic [SUMW_W-1:0] sumw_q;
   logic [SUMP_W-1:0] sump_q;
   logic [SUMW_W-1:0] sumw_sat;
   logic [SUMP_W-1:0] sump_sat;

   assign sumw_sat = (32'(tree_sum) > 32'(SUMW_MAX)) ? SUMW_MAX : SUMW_W'(tree_sum);
   assign sump_sat = (32'(tree_sum) > 32'(SUMP_MAX)) ? SUMP_MAX : SUMP_W'(tree_sum);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sumw_q <= '0;
         sump_q <= '0;
      end else begin
         if (cap_w) sumw_q <= sumw_sat;
         if (cap_p) sump_q <= sump_sat;
      end
   end

   // quotient lookup
   logic [ADDR_W-1:0] addr_q;
   logic [OUT_W-1:0]  tbl_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (rd_q) addr_q <= {sump_q, sumw_q};
   end

   fz_cog_qtable #(
      .SUMW_W(SUMW_W), .SUMP_W(SUMP_W), .OUT_W(OUT_W),
      .SCALE(SCALE), .TABLE_ROM(TABLE_ROM)
   ) u_qtab (
      .addr_i (addr_q),
      .data_o (tbl_data)
   );

   logic [OUT_W-1:0] crisp_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crisp_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= out_en;
         if (out_en) crisp_q <= tbl_data;
      end
   end

   assign crisp_o = crisp_q;
   assign done_o  = done_q;

endmodule

// File: rtl/fz_cog_chk.sv
module fz_cog_chk #(
   parameter int unsigned NST   = 10,
   parameter int unsigned OUT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             lat_in_o,
   input logic             lat_min_o,
   input logic             lat_red_o,
   input logic             done_o,
   input logic [OUT_W-1:0] crisp_o,
   input logic [NST-1:0]   ctl_state
);

   p_onehot_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctl_state) == 1);

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_crisp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(crisp_o));

   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lat_in_o, lat_min_o, lat_red_o, done_o}));

   p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_in_o || lat_min_o || lat_red_o) |=> !(lat_in_o || lat_min_o || lat_red_o));

   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !ctl_state[0]) |=> !lat_in_o);

endmodule

bind fz_cog_defuzz fz_cog_chk #(
   .NST   (fz_cog_pkg::NST),
   .OUT_W (OUT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .lat_in_o  (lat_in_o),
   .lat_min_o (lat_min_o),
   .lat_red_o (lat_red_o),
   .done_o    (done_o),
   .crisp_o   (crisp_o),
   .ctl_state (ctl_state)
);

// File: tb/tb_fz_cog_defuzz.sv
module tb_fz_cog_defuzz;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] wgt = '0;
   logic [31:0] prod = '0;
   logic [7:0]  crisp;
   logic        done, lat_in, lat_min, lat_red;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   fz_cog_defuzz dut (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .wgt_i(wgt), .prod_i(prod),
      .crisp_o(crisp), .done_o(done),
      .lat_in_o(lat_in), .lat_min_o(lat_min), .lat_red_o(lat_red)
   );

   function automatic int exp_crisp(input logic [15:0] w, input logic [31:0] p);
      int sw = 0;
      int sp = 0;
      int q;
      for (int i = 0; i < 4; i++) begin
         sw += int'(w[4*i +: 4]);
         sp += int'(p[8*i +: 8]);
      end
      if (sw > 31)  sw = 31;
      if (sp > 511) sp = 511;
      if (sw == 0) return 0;
      q = (32 * sp + sw) / (2 * sw);
      return (q > 255) ? 255 : q;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // wa/pa at start, wb/pb from cycle 5, wc/pc from cycle 12
   task automatic run_case(input logic [15:0] wa, input logic [31:0] pa,
                           input logic [15:0] wb, input logic [31:0] pb,
                           input logic [15:0] wc, input logic [31:0] pc,
                           input bit poke, input string req);
      int c_in = 0, c_min = 0, c_red = 0, c_done = 0;
      int n_in = 0, n_min = 0, n_red = 0, n_done = 0;
      int got = -1;
      int e;
      @(negedge clk);
      wgt = wa; prod = pa; start = 1'b1;
      for (int c = 1; c <= 60; c++) begin
         @(posedge clk);
         @(negedge clk);
         start = poke && (c == 9 || c == 18);
         if (c == 5)  begin wgt = wb; prod = pb; end
         if (c == 12) begin wgt = wc; prod = pc; end
         if (lat_in)  begin n_in++;  if (c_in == 0)  c_in = c;  end
         if (lat_min) begin n_min++; if (c_min == 0) c_min = c; end
         if (lat_red) begin n_red++; if (c_red == 0) c_red = c; end
         if (done) begin
            n_done++;
            if (c_done == 0) begin c_done = c; got = int'(crisp); end
         end
      end
      start = 1'b0;
      e = exp_crisp(wb, pb);
      chk(got == e, req, got, e);
      chk(c_in == 1 && n_in == 1, "R5 lat_in timing", c_in * 100 + n_in, 101);
      chk(c_min == 4 && n_min == 1, "R5 lat_min timing", c_min * 100 + n_min, 401);
      chk(c_red == 7 && n_red == 1, "R5 lat_red timing", c_red * 100 + n_red, 701);
      chk(c_done == 24, "R6 done cycle", c_done, 24);
      chk(n_done == 1, poke ? "R9 single done" : "R6 single done", n_done, 1);
      chk(int'(crisp) == e, "R6 crisp held", int'(crisp), e);
   endtask

   task automatic run_plain(input logic [15:0] w, input logic [31:0] p, input string req);
      run_case(w, p, w, p, w, p, 1'b0, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] rw;
      logic [31:0] rp;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(crisp == 8'd0 && !done && !lat_in && !lat_min && !lat_red,
          "R10 reset outputs", int'({crisp, done, lat_in, lat_min, lat_red}), 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // directed corner cases
      run_plain(16'h000F, {24'd0, 8'd135}, "R1 single rule top location");
      run_plain(16'h0000, 32'h0000_0000, "R2 zero weight total");
      run_plain(16'h0000, 32'h1122_3344, "R2 zero weights with products");
      run_plain(16'h1FFF, {8'd0, 8'd10, 8'd10, 8'd10}, "R3 weight total clamped");
      run_plain(16'hFFFF, {8'd135, 8'd135, 8'd135, 8'd135}, "R3 both totals clamped");
      run_plain(16'h0001, {24'd0, 8'd100}, "R4 quotient clamped");
      run_plain(16'h0003, {24'd0, 8'd2}, "R1 rounding up");
      run_plain(16'h0003, {24'd0, 8'd1}, "R1 rounding down");

      // sampling edge and busy start
      run_case(16'h0001, {24'd0, 8'd9}, 16'h4321, {8'd36, 8'd9, 8'd20, 8'd5},
               16'hFFFF, 32'hFFFF_FFFF, 1'b0, "R8 inputs sampled at edge 11");
      run_case(16'h0123, {8'd21, 8'd8, 8'd2, 8'd0}, 16'h0123, {8'd21, 8'd8, 8'd2, 8'd0},
               16'h0001, {24'd0, 8'd1}, 1'b1, "R9 start while busy ignored");

      // constrained random: products are weight times a location 1..9
      for (int n = 0; n < 24; n++) begin
         for (int k = 0; k < 4; k++) begin
            int wk = (n < 12) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 15));
            int zk = int'($urandom_range(1, 9));
            rw[4*k +: 4] = 4'(wk);
            rp[8*k +: 8] = 8'(wk * zk);
         end
         run_plain(rw, rp, "R1 random weights");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule